// File: doc/BRIEF.md
# Asynchronous Static Memory Wait-State Controller

This controller carries single read and write requests from an on-chip bus, clocked by the system clock, out to an external asynchronous SRAM or flash device with a 16-bit data bus. It drives an active-low chip select, output enable and write enable, a pair of active-low byte-lane enables, a half-word address and the outgoing data. All memory-side timing is counted in memory ticks. A tick lasts a programmable number of system cycles, so the external strobes run from a divided clock while the block itself stays in the system clock domain.

The number of ticks a read holds its strobes and the number a write holds them are programmed separately. The write-enable pulse length is a third field. A request is offered with a valid/ready handshake, and the block takes one only while it is idle. Byte and half-word requests each use one memory cycle, with identical timing. A word request is split into two half-word memory cycles with a short chip-select-high gap between them. The block signals completion once, with the read data assembled into 32 bits.

Top module: `asram_wait_ctrl`

## Requirements
- R1: After reset, chip select, output enable and write enable are high, the data bus is not driven, `rsp_done` is low and `req_ready` is high.
- R2: `req_ready` is high exactly while the block is idle. A request is taken on the rising edge where `req_valid` and `req_ready` are both high. While an access is running, `req_ready` is low and chip select is low only during memory cycles.
- R3: A read memory cycle holds chip select and output enable low for `cfg_rd_wait`+1 ticks. The data bus input is sampled in the last system cycle of that window.
- R4: A write memory cycle holds chip select low and drives the data bus for `cfg_wr_wait`+1 ticks. Write enable is low for the first min(`cfg_we_len`, `cfg_wr_wait`+1) ticks of the cycle, and only while the data bus is driven.
- R5: `rsp_done` is a single-cycle pulse. It is high in the first system cycle after the final memory cycle, when chip select and write enable are already high. `rsp_rdata` is valid while `rsp_done` is high.
- R6: One tick lasts `cfg_clk_div`+1 system cycles, counted from the cycle after the request is taken. A single-cycle access completes `len`·(`cfg_clk_div`+1)+1 cycles after acceptance, where `len` is the read or write tick count.
- R7: Size code 2 or 3 (word) makes two memory cycles. The low half goes to half-word address `req_addr`>>1 and the high half to the next address. A one-tick chip-select-high gap separates the two cycles. A read returns the first half in `rsp_rdata[15:0]` and the second half in `rsp_rdata[31:16]`. The latency is 2·`len`·D + D + 1, where D = `cfg_clk_div`+1.
- R8: For size code 0 (byte), address bit 0 = 0 selects the low lane (`mem_be_n`=2'b10) and bit 0 = 1 selects the high lane (`mem_be_n`=2'b01). Write data bits [7:0] are driven on both lanes. A byte read returns the selected lane in bits [7:0], with zeros above. Half-word and word accesses drive `mem_be_n`=2'b00.
- R9: Size codes 0 (byte) and 1 (half-word) give the same memory-cycle timing and latency. A half-word read returns the bus zero-extended.
- R10: Output enable is low only during read memory cycles, never while the data bus is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rd_wait | input | WAIT_W | Read wait ticks (cycle is this +1 ticks) |
| cfg_wr_wait | input | WAIT_W | Write wait ticks (cycle is this +1 ticks) |
| cfg_we_len | input | WAIT_W | Write-enable low length in ticks |
| cfg_clk_div | input | DIV_W | Tick length minus one, in system cycles |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half-word, 2/3 word |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | Completion pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_done |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | 2 | Byte-lane enables, active low |
| mem_addr | output | ADDR_W-1 | Half-word address |
| mem_dq_out | output | 16 | Data to memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Data from memory |

## Verification
If the tick divider or the tick counter drifted, the latency from acceptance to `rsp_done` and the number of cycles with a strobe low would be wrong. That shows up in the first transaction after the fault. A lost or swapped half-word flag would put the high half at the wrong address or in the wrong half of `rsp_rdata`, visible when the word is written and then read back. A wrong phase would show as a strobe overlapping the driven bus, or as `req_ready` high during an access, within the cycle it happens.

// File: rtl/asram_pkg.sv
package asram_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_XFER = 2'd1,
        PH_GAP  = 2'd2,
        PH_FIN  = 2'd3
    } phase_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/asram_tick.sv
module asram_tick #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] cfg_clk_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == cfg_clk_div);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic              run,
    input  logic [WAIT_W-1:0] cfg_rd_wait,
    input  logic [WAIT_W-1:0] cfg_wr_wait,
    input  logic [WAIT_W-1:0] cfg_we_len,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [1:0]        mem_be_n,
    output logic [ADDR_W-2:0] mem_addr,
    output logic [HALF_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [HALF_W-1:0] mem_dq_in
);
    typedef struct packed {
        phase_e             phase;
        logic [WAIT_W-1:0]  tcnt;
        logic               upper;
        logic               wr;
        logic [1:0]         size;
        logic [ADDR_W-1:0]  addr;
        logic [WORD_W-1:0]  wdata;
        logic [WORD_W-1:0]  rdata;
    } seq_t;

    seq_t s_d, s_q;
    logic [WAIT_W-1:0] last_tick;
    logic              is_word, in_xfer;

    always_comb begin
        s_d       = s_q;
        is_word   = s_q.size[1];
        last_tick = s_q.wr ? cfg_wr_wait : cfg_rd_wait;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.phase = PH_XFER;
                    s_d.tcnt  = '0;
                    s_d.upper = 1'b0;
                    s_d.wr    = req_write;
                    s_d.size  = req_size;
                    s_d.addr  = req_addr;
                    s_d.wdata = req_wdata;
                    s_d.rdata = '0;
                end
            end
            PH_XFER: begin
                if (tick) begin
                    if (s_q.tcnt == last_tick) begin
                        if (!s_q.wr) begin
                            if (is_word) begin
                                if (s_q.upper) s_d.rdata[31:16] = mem_dq_in;
                                else           s_d.rdata[15:0]  = mem_dq_in;
                            end else if (s_q.size == SZ_HALF) begin
                                s_d.rdata = {16'h0, mem_dq_in};
                            end else begin
                                s_d.rdata = {24'h0, s_q.addr[0] ? mem_dq_in[15:8] : mem_dq_in[7:0]};
                            end
                        end
                        s_d.tcnt  = '0;
                        s_d.phase = (is_word && !s_q.upper) ? PH_GAP : PH_FIN;
                    end else begin
                        s_d.tcnt = s_q.tcnt + 1'b1;
                    end
                end
            end
            PH_GAP: begin
                if (tick) begin
                    s_d.phase = PH_XFER;
                    s_d.upper = 1'b1;
                    s_d.tcnt  = '0;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        in_xfer    = (s_q.phase == PH_XFER);
        run        = in_xfer || (s_q.phase == PH_GAP);
        req_ready  = (s_q.phase == PH_IDLE);
        rsp_done   = (s_q.phase == PH_FIN);
        rsp_rdata  = s_q.rdata;
        mem_cs_n   = !in_xfer;
        mem_oe_n   = !(in_xfer && !s_q.wr);
        mem_we_n   = !(in_xfer && s_q.wr && (s_q.tcnt < cfg_we_len));
        mem_dq_oe  = in_xfer && s_q.wr;
        mem_addr   = s_q.addr[ADDR_W-1:1] + {{(ADDR_W-2){1'b0}}, s_q.upper};
        if (s_q.size == SZ_BYTE) begin
            mem_dq_out = {2{s_q.wdata[7:0]}};
            mem_be_n   = s_q.addr[0] ? 2'b01 : 2'b10;
        end else begin
            mem_dq_out = s_q.upper ? s_q.wdata[31:16] : s_q.wdata[15:0];
            mem_be_n   = 2'b00;
        end
    end

    p_idle_no_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_cs_n);
    p_oe_read_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_cs_n && !mem_dq_oe));
    p_we_inside_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_dq_oe));
    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    p_done_strobes_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (mem_cs_n && mem_we_n && !req_ready));
    p_gap_keeps_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_cs_n) && !rsp_done && !req_ready) |=> $stable(rsp_rdata));
endmodule

// File: rtl/asram_wait_ctrl.sv
module asram_wait_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int WAIT_W = 4,
    parameter int DIV_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WAIT_W-1:0] cfg_rd_wait,
    input  logic [WAIT_W-1:0] cfg_wr_wait,
    input  logic [WAIT_W-1:0] cfg_we_len,
    input  logic [DIV_W-1:0]  cfg_clk_div,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_done,
    output logic [31:0]       rsp_rdata,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [1:0]        mem_be_n,
    output logic [ADDR_W-2:0] mem_addr,
    output logic [15:0]       mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [15:0]       mem_dq_in
);
    logic tick, run;

    asram_tick #(.DIV_W(DIV_W)) u_tick (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .cfg_clk_div (cfg_clk_div),
        .tick        (tick)
    );

    asram_seq #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .run         (run),
        .cfg_rd_wait (cfg_rd_wait),
        .cfg_wr_wait (cfg_wr_wait),
        .cfg_we_len  (cfg_we_len),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_size    (req_size),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .rsp_done    (rsp_done),
        .rsp_rdata   (rsp_rdata),
        .mem_cs_n    (mem_cs_n),
        .mem_oe_n    (mem_oe_n),
        .mem_we_n    (mem_we_n),
        .mem_be_n    (mem_be_n),
        .mem_addr    (mem_addr),
        .mem_dq_out  (mem_dq_out),
        .mem_dq_oe   (mem_dq_oe),
        .mem_dq_in   (mem_dq_in)
    );
endmodule

// File: tb/sim_asram_wait_ctrl.sv
module sim_asram_wait_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 24;
    localparam int WAIT_W = 4;
    localparam int DIV_W  = 2;

    typedef struct packed {
        logic        wr;
        logic [1:0]  size;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [3:0]  rdw;
        logic [3:0]  wrw;
        logic [3:0]  wel;
        logic [1:0]  div;
        logic [31:0] exp_rd;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd2, 8'h04, 32'h89AB_CDEF, 4'd3, 4'd2, 4'd2, 2'd1, 32'h0},
        '{1'b0, 2'd2, 8'h04, 32'h0,         4'd3, 4'd2, 4'd2, 2'd1, 32'h89AB_CDEF},
        '{1'b1, 2'd1, 8'h0A, 32'h0000_1234, 4'd1, 4'd1, 4'd1, 2'd0, 32'h0},
        '{1'b0, 2'd1, 8'h0A, 32'h0,         4'd1, 4'd1, 4'd1, 2'd0, 32'h0000_1234},
        '{1'b1, 2'd0, 8'h0C, 32'h0000_0055, 4'd2, 4'd2, 4'd3, 2'd1, 32'h0},
        '{1'b1, 2'd0, 8'h0D, 32'h0000_00AA, 4'd2, 4'd2, 4'd1, 2'd1, 32'h0},
        '{1'b0, 2'd1, 8'h0C, 32'h0,         4'd2, 4'd2, 4'd1, 2'd1, 32'h0000_AA55},
        '{1'b0, 2'd0, 8'h0D, 32'h0,         4'd2, 4'd2, 4'd1, 2'd1, 32'h0000_00AA},
        '{1'b0, 2'd0, 8'h0C, 32'h0,         4'd2, 4'd2, 4'd1, 2'd1, 32'h0000_0055},
        '{1'b1, 2'd3, 8'h10, 32'hCAFE_F00D, 4'd1, 4'd4, 4'd1, 2'd3, 32'h0},
        '{1'b0, 2'd2, 8'h10, 32'h0,         4'd0, 4'd4, 4'd1, 2'd2, 32'hCAFE_F00D}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [WAIT_W-1:0] cfg_rd_wait = '0, cfg_wr_wait = '0, cfg_we_len = '0;
    logic [DIV_W-1:0]  cfg_clk_div = '0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_size = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic req_ready, rsp_done, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [31:0] rsp_rdata;
    logic [1:0] mem_be_n;
    logic [ADDR_W-2:0] mem_addr;
    logic [15:0] mem_dq_out, mem_dq_in;
    logic [15:0] mem [16];

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    asram_wait_ctrl #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W), .DIV_W(DIV_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_rd_wait(cfg_rd_wait), .cfg_wr_wait(cfg_wr_wait),
        .cfg_we_len(cfg_we_len), .cfg_clk_div(cfg_clk_div),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // memory model: combinational read, byte-lane write while write enable low
    assign mem_dq_in = (!mem_oe_n && !mem_cs_n) ? mem[mem_addr[3:0]] : 16'hDEAD;
    always @(posedge clk) begin
        if (!mem_we_n && !mem_cs_n) begin
            if (!mem_be_n[0]) mem[mem_addr[3:0]][7:0]  <= mem_dq_out[7:0];
            if (!mem_be_n[1]) mem[mem_addr[3:0]][15:8] <= mem_dq_out[15:8];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input string tag);
        int lat, we_low, oe_low, busy_ready, len, dv, halves, exp_lat, exp_we;
        lat = 0; we_low = 0; oe_low = 0; busy_ready = 0;
        @(negedge clk);
        cfg_rd_wait = v.rdw; cfg_wr_wait = v.wrw; cfg_we_len = v.wel;
        cfg_clk_div = v.div;
        req_valid = 1'b1; req_write = v.wr; req_size = v.size;
        req_addr = {16'h0, v.addr}; req_wdata = v.wdata;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_done && lat < 1000) begin
            if (!mem_we_n) we_low++;
            if (!mem_oe_n) oe_low++;
            if (req_ready) busy_ready++;
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        len    = (v.wr ? int'(v.wrw) : int'(v.rdw)) + 1;
        dv     = int'(v.div) + 1;
        halves = v.size[1] ? 2 : 1;
        exp_lat = v.size[1] ? (2*len*dv + dv + 1) : (len*dv + 1);
        exp_we  = v.wr ? ((int'(v.wel) < len ? int'(v.wel) : len) * dv * halves) : 0;
        check(lat == exp_lat, tag, "latency R6 R7 R9", lat, exp_lat);
        check(busy_ready == 0, "R2", "ready while busy", busy_ready, 0);
        if (v.wr) begin
            check(we_low == exp_we, "R4", "write enable low cycles", we_low, exp_we);
            check(oe_low == 0, "R10", "output enable during write", oe_low, 0);
        end else begin
            check(oe_low == len*dv*halves, "R3", "output enable low cycles", oe_low, len*dv*halves);
            check(rsp_rdata == v.exp_rd, tag, "read data R3 R8", rsp_rdata, v.exp_rd);
        end
        @(negedge clk);
        check(!rsp_done && req_ready, "R5", "done is one cycle", rsp_done, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 16'h0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(mem_cs_n && mem_oe_n && mem_we_n, "R1", "strobes in reset",
              {29'h0, mem_cs_n, mem_oe_n, mem_we_n}, 32'h7);
        check(!mem_dq_oe && !rsp_done && req_ready, "R1", "bus and handshake in reset",
              {29'h0, mem_dq_oe, rsp_done, req_ready}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_cs_n && req_ready, "R1", "idle after reset release", {31'h0, mem_cs_n}, 1);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], VECS[i].size[1] ? "R7" : (VECS[i].size == 2'd0 ? "R8" : "R9"));
        end

        // directed: word halves land at base and base+1 (R7)
        check(mem[2] == 16'hCDEF, "R7", "low half at base", {16'h0, mem[2]}, 32'hCDEF);
        check(mem[3] == 16'h89AB, "R7", "high half at base+1", {16'h0, mem[3]}, 32'h89AB);
        // directed: byte lanes selected by address bit 0 (R8)
        check(mem[6] == 16'hAA55, "R8", "byte lanes merged", {16'h0, mem[6]}, 32'hAA55);
        // directed: byte and half read take the same time (R9)
        run_vec('{1'b0, 2'd0, 8'h0A, 32'h0, 4'd5, 4'd1, 4'd1, 2'd2, 32'h0000_0034}, "R9");
        run_vec('{1'b0, 2'd1, 8'h0A, 32'h0, 4'd5, 4'd1, 4'd1, 2'd2, 32'h0000_1234}, "R9");
        // directed: pulse longer than the write cycle is clamped (R4)
        run_vec('{1'b1, 2'd1, 8'h1E, 32'h0000_BEEF, 4'd0, 4'd1, 4'd9, 2'd0, 32'h0}, "R4");
        check(mem[15] == 16'hBEEF, "R4", "clamped write stored", {16'h0, mem[15]}, 32'hBEEF);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule